// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block draws into a linear, byte-addressed framebuffer. It accepts one operation at a time through a valid/ready handshake. An operation is either a solid fill of a rectangle with a colour, or a screen-to-screen copy of one rectangle onto another. The pixel size in bytes follows the configured colour depth. The row pitch is that pixel size times the configured screen width. The engine turns rectangle coordinates into byte addresses and walks the rectangle one byte at a time through a simple memory read/write port.

A fill writes the low colour bytes, repeated, across the first row of the rectangle. Each later row is then produced by reading the matching byte of the first row and writing it down. A copy picks its row order and its byte order within a row so that a source and destination that overlap still give the result of copying from an untouched snapshot of the source. When an operation has touched memory, the engine reports the destination rectangle as a dirty region for one cycle. Command parsing and display scan-out are done by neighbouring blocks.

Top module: `rfe_engine`

## Requirements
- R1: The pixel size is bpp = (cfg_depth + 7) >> 3 bytes for a depth of 1 to 32. The pitch is bpp × cfg_scr_w bytes. The first byte of a rectangle at (x, y) is at bpp × x + pitch × y. Each row spans bpp × width bytes.
- R2: A fill (op_kind = 0) gives byte k of every row of the rectangle (k = 0 at the left) the colour byte k mod bpp. Colour byte 0 is op_colour[7:0], byte 1 is op_colour[15:8], and so on.
- R3: A copy (op_kind = 1) between rectangles that do not overlap makes the destination equal to the source.
- R4: A copy whose destination y exceeds its source y walks rows from the last one upward. An overlapping copy of this kind gives the same result as a copy from the original source contents.
- R5: A copy whose destination y is below its source y walks rows from the top down. An overlapping copy of this kind gives the same result as a copy from the original source contents.
- R6: A copy with equal source and destination y and a larger destination x walks each row from its highest byte address down. An overlapping copy of this kind gives the original source contents.
- R7: A copy with equal y and a smaller destination x walks each row upward. An overlapping copy of this kind gives the original source contents.
- R8: When an operation with non-zero size completes, dirty_valid is high for exactly one cycle with the destination x, y, width and height. op_ready is high in the following cycle.
- R9: An operation with zero width or zero height completes on acceptance. It makes no memory access, emits no dirty region, and leaves op_ready high.
- R10: No byte outside the destination rectangle is written.
- R11: Read data is taken from mem_rdata in the cycle after mem_re. Every mem_re is followed in the next cycle by mem_we, and the two strobes are never high together.
- R12: After reset, op_ready is high, both memory strobes are low and dirty_valid is low. op_ready stays low while an operation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_depth | input | 6 | Colour depth in bits, sampled when an operation is accepted |
| cfg_scr_w | input | CRD_W | Screen width in pixels, sampled when an operation is accepted |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Engine idle and able to accept |
| op_kind | input | 1 | 0 = fill, 1 = copy |
| op_src_x | input | CRD_W | Copy source left column |
| op_src_y | input | CRD_W | Copy source top row |
| op_dst_x | input | CRD_W | Destination left column |
| op_dst_y | input | CRD_W | Destination top row |
| op_w | input | CRD_W | Width in pixels |
| op_h | input | CRD_W | Height in rows |
| op_colour | input | 32 | Fill colour, low byte first |
| mem_re | output | 1 | Byte read strobe |
| mem_we | output | 1 | Byte write strobe |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_re |
| dirty_valid | output | 1 | Dirty region report, one cycle |
| dirty_x | output | CRD_W | Dirty region left column |
| dirty_y | output | CRD_W | Dirty region top row |
| dirty_w | output | CRD_W | Dirty region width |
| dirty_h | output | CRD_W | Dirty region height |

## Verification
Fills are run at depths of 8, 15, 16, 24 and 32 bits. These tell apart the rounding of the pixel size and the byte phase of the colour pattern, including the three-byte case that does not divide a word. Copies are run in five arrangements: disjoint, overlapping with the destination lower, overlapping with it higher, and sharing rows with the destination shifted right or left. A wrong row or byte order corrupts only the overlapping cases, so each ordering rule has a case that fails if that rule is broken. The whole memory is compared after every operation, which also catches stray writes. Zero-width and zero-height operations confirm that nothing is touched and nothing is reported.

// File: rtl/rfe_pkg.sv
package rfe_pkg;

    localparam int DEPTH_W  = 6;
    localparam int COLOUR_W = 32;

    typedef enum logic [0:0] {
        OP_FILL = 1'b0,
        OP_COPY = 1'b1
    } op_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FILL0 = 3'd1,
        ST_RD    = 3'd2,
        ST_WR    = 3'd3,
        ST_DONE  = 3'd4
    } walk_state_e;

    // Ordering decisions taken once per operation
    typedef struct packed {
        logic is_copy;
        logic rev_rows;   // start at the last row, step back by one pitch
        logic desc_cols;  // walk bytes of a row from high to low address
    } walk_flags_t;

    // Bytes per pixel, rounded up from the depth in bits
    function automatic logic [3:0] px_bytes(input logic [DEPTH_W-1:0] depth);
        logic [DEPTH_W:0] t;
        t = {1'b0, depth} + (DEPTH_W+1)'(7);
        return t[DEPTH_W:3];
    endfunction

    // Pick colour byte idx, byte 0 being the least significant
    function automatic logic [7:0] colour_byte(input logic [COLOUR_W-1:0] c,
                                               input logic [1:0] idx);
        return c[{idx, 3'b000} +: 8];
    endfunction

endpackage

// File: rtl/rfe_geom.sv
module rfe_geom
    import rfe_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CRD_W  = 12,
    parameter int LB_W   = CRD_W + 4
) (
    input  logic [DEPTH_W-1:0] depth,
    input  logic [CRD_W-1:0]   scr_w,
    input  op_kind_e           kind,
    input  logic [CRD_W-1:0]   sx,
    input  logic [CRD_W-1:0]   sy,
    input  logic [CRD_W-1:0]   dx,
    input  logic [CRD_W-1:0]   dy,
    input  logic [CRD_W-1:0]   w,
    input  logic [CRD_W-1:0]   h,
    output logic [3:0]         bpp,
    output logic [ADDR_W-1:0]  pitch,
    output logic [LB_W-1:0]    line_bytes,
    output logic [ADDR_W-1:0]  src_first,
    output logic [ADDR_W-1:0]  dst_first,
    output walk_flags_t        flags
);

    localparam int N_CORNER = 2;

    logic [CRD_W-1:0]  cx [N_CORNER];
    logic [CRD_W-1:0]  cy [N_CORNER];
    logic [ADDR_W-1:0] first [N_CORNER];
    logic [ADDR_W-1:0] last_row_off;

    assign bpp        = px_bytes(depth);
    assign pitch      = ADDR_W'(bpp) * ADDR_W'(scr_w);
    assign line_bytes = LB_W'(bpp) * LB_W'(w);

    always_comb begin
        flags.is_copy   = (kind == OP_COPY);
        flags.rev_rows  = flags.is_copy && (dy > sy);
        flags.desc_cols = flags.is_copy && (dy == sy) && (dx > sx);
    end

    // Rows are walked bottom-up when reversed: both pointers start at row h-1
    assign last_row_off = flags.rev_rows ? pitch * ADDR_W'(h - CRD_W'(1)) : '0;

    assign cx[0] = sx;
    assign cy[0] = sy;
    assign cx[1] = dx;
    assign cy[1] = dy;

    for (genvar i = 0; i < N_CORNER; i++) begin : g_corner
        assign first[i] = ADDR_W'(bpp) * ADDR_W'(cx[i])
                        + pitch * ADDR_W'(cy[i])
                        + last_row_off;
    end

    assign src_first = first[0];
    assign dst_first = first[1];

endmodule

// File: rtl/rfe_walker.sv
module rfe_walker
    import rfe_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CRD_W  = 12,
    parameter int LB_W   = CRD_W + 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  walk_flags_t         flags,
    input  logic [COLOUR_W-1:0] colour,
    input  logic [3:0]          bpp,
    input  logic [ADDR_W-1:0]   pitch,
    input  logic [LB_W-1:0]     line_bytes,
    input  logic [CRD_W-1:0]    h,
    input  logic [ADDR_W-1:0]   src_first,
    input  logic [ADDR_W-1:0]   dst_first,
    output logic                busy,
    output logic                done,
    output logic                mem_re,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [7:0]          mem_wdata,
    input  logic [7:0]          mem_rdata
);

    walk_state_e         state;
    walk_flags_t         flags_q;
    logic [COLOUR_W-1:0] colour_q;
    logic [3:0]          bpp_q;
    logic [ADDR_W-1:0]   pitch_q;
    logic [LB_W-1:0]     nbytes_q;
    logic [CRD_W-1:0]    h_q;
    logic [ADDR_W-1:0]   src_row;
    logic [ADDR_W-1:0]   dst_row;
    logic [LB_W-1:0]     col_cnt;
    logic [CRD_W-1:0]    row_cnt;
    logic [1:0]          ph;

    logic [LB_W-1:0]     col_off;
    logic                last_col;
    logic                last_row;
    logic [ADDR_W-1:0]   src_next;
    logic [ADDR_W-1:0]   dst_next;

    assign col_off  = flags_q.desc_cols ? (nbytes_q - LB_W'(1) - col_cnt) : col_cnt;
    assign last_col = (col_cnt == nbytes_q - LB_W'(1));
    assign last_row = (row_cnt == h_q - CRD_W'(1));
    assign src_next = flags_q.rev_rows ? src_row - pitch_q : src_row + pitch_q;
    assign dst_next = flags_q.rev_rows ? dst_row - pitch_q : dst_row + pitch_q;

    assign busy      = (state != ST_IDLE);
    assign done      = (state == ST_DONE);
    assign mem_re    = (state == ST_RD);
    assign mem_we    = (state == ST_FILL0) || (state == ST_WR);
    assign mem_addr  = ((state == ST_RD) ? src_row : dst_row) + ADDR_W'(col_off);
    assign mem_wdata = (state == ST_FILL0) ? colour_byte(colour_q, ph) : mem_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            flags_q  <= '0;
            colour_q <= '0;
            bpp_q    <= '0;
            pitch_q  <= '0;
            nbytes_q <= '0;
            h_q      <= '0;
            src_row  <= '0;
            dst_row  <= '0;
            col_cnt  <= '0;
            row_cnt  <= '0;
            ph       <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        flags_q  <= flags;
                        colour_q <= colour;
                        bpp_q    <= bpp;
                        pitch_q  <= pitch;
                        nbytes_q <= line_bytes;
                        h_q      <= h;
                        // a fill replicates its own first row
                        src_row  <= flags.is_copy ? src_first : dst_first;
                        dst_row  <= dst_first;
                        col_cnt  <= '0;
                        row_cnt  <= '0;
                        ph       <= '0;
                        state    <= flags.is_copy ? ST_RD : ST_FILL0;
                    end
                end
                ST_FILL0: begin
                    ph <= ({2'b00, ph} == bpp_q - 4'd1) ? 2'd0 : ph + 2'd1;
                    if (last_col) begin
                        col_cnt <= '0;
                        if (last_row) begin
                            state <= ST_DONE;
                        end else begin
                            row_cnt <= row_cnt + CRD_W'(1);
                            dst_row <= dst_next;
                            state   <= ST_RD;
                        end
                    end else begin
                        col_cnt <= col_cnt + LB_W'(1);
                    end
                end
                ST_RD: begin
                    state <= ST_WR;
                end
                ST_WR: begin
                    if (last_col) begin
                        col_cnt <= '0;
                        if (last_row) begin
                            state <= ST_DONE;
                        end else begin
                            row_cnt <= row_cnt + CRD_W'(1);
                            dst_row <= dst_next;
                            if (flags_q.is_copy) src_row <= src_next;
                            state <= ST_RD;
                        end
                    end else begin
                        col_cnt <= col_cnt + LB_W'(1);
                        state   <= ST_RD;
                    end
                end
                ST_DONE: begin
                    state <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    AST_ROW_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> (row_cnt < h_q)); // R10
    AST_COL_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> (col_cnt < nbytes_q)); // R10
    AST_NO_RW_BOTH: assert property (@(posedge clk) disable iff (rst)
        !(mem_re && mem_we)); // R11

endmodule

// File: rtl/rfe_dirty.sv
module rfe_dirty #(
    parameter int CRD_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic [CRD_W-1:0] x,
    input  logic [CRD_W-1:0] y,
    input  logic [CRD_W-1:0] w,
    input  logic [CRD_W-1:0] h,
    input  logic             done,
    output logic             valid,
    output logic [CRD_W-1:0] out_x,
    output logic [CRD_W-1:0] out_y,
    output logic [CRD_W-1:0] out_w,
    output logic [CRD_W-1:0] out_h
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_x <= '0;
            out_y <= '0;
            out_w <= '0;
            out_h <= '0;
        end else if (capture) begin
            out_x <= x;
            out_y <= y;
            out_w <= w;
            out_h <= h;
        end
    end

    assign valid = done;

endmodule

// File: rtl/rfe_engine.sv
module rfe_engine
    import rfe_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CRD_W  = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DEPTH_W-1:0]  cfg_depth,
    input  logic [CRD_W-1:0]    cfg_scr_w,
    input  logic                op_valid,
    output logic                op_ready,
    input  logic                op_kind,
    input  logic [CRD_W-1:0]    op_src_x,
    input  logic [CRD_W-1:0]    op_src_y,
    input  logic [CRD_W-1:0]    op_dst_x,
    input  logic [CRD_W-1:0]    op_dst_y,
    input  logic [CRD_W-1:0]    op_w,
    input  logic [CRD_W-1:0]    op_h,
    input  logic [COLOUR_W-1:0] op_colour,
    output logic                mem_re,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [7:0]          mem_wdata,
    input  logic [7:0]          mem_rdata,
    output logic                dirty_valid,
    output logic [CRD_W-1:0]    dirty_x,
    output logic [CRD_W-1:0]    dirty_y,
    output logic [CRD_W-1:0]    dirty_w,
    output logic [CRD_W-1:0]    dirty_h
);

    localparam int LB_W = CRD_W + 4;

    logic              accept;
    logic              start;
    logic              busy;
    logic              done;
    logic [3:0]        bpp;
    logic [ADDR_W-1:0] pitch;
    logic [LB_W-1:0]   line_bytes;
    logic [ADDR_W-1:0] src_first;
    logic [ADDR_W-1:0] dst_first;
    walk_flags_t       flags;

    assign op_ready = !busy;
    assign accept   = op_valid && op_ready;
    // an empty rectangle is retired on acceptance
    assign start    = accept && (op_w != '0) && (op_h != '0);

    rfe_geom #(.ADDR_W(ADDR_W), .CRD_W(CRD_W), .LB_W(LB_W)) u_geom (
        .depth      (cfg_depth),
        .scr_w      (cfg_scr_w),
        .kind       (op_kind_e'(op_kind)),
        .sx         (op_src_x),
        .sy         (op_src_y),
        .dx         (op_dst_x),
        .dy         (op_dst_y),
        .w          (op_w),
        .h          (op_h),
        .bpp        (bpp),
        .pitch      (pitch),
        .line_bytes (line_bytes),
        .src_first  (src_first),
        .dst_first  (dst_first),
        .flags      (flags)
    );

    rfe_walker #(.ADDR_W(ADDR_W), .CRD_W(CRD_W), .LB_W(LB_W)) u_walk (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .flags      (flags),
        .colour     (op_colour),
        .bpp        (bpp),
        .pitch      (pitch),
        .line_bytes (line_bytes),
        .h          (op_h),
        .src_first  (src_first),
        .dst_first  (dst_first),
        .busy       (busy),
        .done       (done),
        .mem_re     (mem_re),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata)
    );

    rfe_dirty #(.CRD_W(CRD_W)) u_dirty (
        .clk     (clk),
        .rst     (rst),
        .capture (start),
        .x       (op_dst_x),
        .y       (op_dst_y),
        .w       (op_w),
        .h       (op_h),
        .done    (done),
        .valid   (dirty_valid),
        .out_x   (dirty_x),
        .out_y   (dirty_y),
        .out_w   (dirty_w),
        .out_h   (dirty_h)
    );

    AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (rst)
        mem_re |=> mem_we); // R11
    AST_DIRTY_NONZERO: assert property (@(posedge clk) disable iff (rst)
        dirty_valid |-> (dirty_w != '0) && (dirty_h != '0)); // R9
    AST_DIRTY_THEN_READY: assert property (@(posedge clk) disable iff (rst)
        dirty_valid |=> (op_ready && !dirty_valid)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        op_ready |-> (!mem_re && !mem_we && !dirty_valid)); // R12

endmodule

// File: tb/sim_rfe_engine.sv
module sim_rfe_engine;

    localparam int ADDR_W = 24;
    localparam int CRD_W  = 12;
    localparam int SW     = 16;
    localparam int MEMSZ  = 2048;

    typedef struct packed {
        logic        kind;
        logic [5:0]  depth;
        logic [7:0]  sx;
        logic [7:0]  sy;
        logic [7:0]  dx;
        logic [7:0]  dy;
        logic [7:0]  w;
        logic [7:0]  h;
        logic [31:0] col;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 6'd32, 8'd0, 8'd0, 8'd2, 8'd1, 8'd3, 8'd2, 32'hA1B2C3D4},
        '{1'b0, 6'd24, 8'd0, 8'd0, 8'd1, 8'd3, 8'd4, 8'd3, 32'h00112233},
        '{1'b0, 6'd16, 8'd0, 8'd0, 8'd5, 8'd0, 8'd5, 8'd4, 32'h0000BEEF},
        '{1'b0, 6'd8,  8'd0, 8'd0, 8'd0, 8'd7, 8'd7, 8'd1, 32'h0000005A},
        '{1'b0, 6'd15, 8'd0, 8'd0, 8'd3, 8'd2, 8'd2, 8'd2, 32'h00007F31},
        '{1'b1, 6'd32, 8'd0, 8'd0, 8'd8, 8'd6, 8'd3, 8'd2, 32'h0},
        '{1'b1, 6'd16, 8'd2, 8'd2, 8'd3, 8'd4, 8'd5, 8'd4, 32'h0},
        '{1'b1, 6'd16, 8'd2, 8'd5, 8'd1, 8'd3, 8'd5, 8'd4, 32'h0},
        '{1'b1, 6'd8,  8'd1, 8'd4, 8'd3, 8'd4, 8'd6, 8'd3, 32'h0},
        '{1'b1, 6'd8,  8'd4, 8'd4, 8'd1, 8'd4, 8'd6, 8'd3, 32'h0}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [5:0]        cfg_depth = 6'd32;
    logic [CRD_W-1:0]  cfg_scr_w = CRD_W'(SW);
    logic              op_valid = 1'b0;
    logic              op_ready;
    logic              op_kind = 1'b0;
    logic [CRD_W-1:0]  op_src_x = '0, op_src_y = '0, op_dst_x = '0, op_dst_y = '0;
    logic [CRD_W-1:0]  op_w = '0, op_h = '0;
    logic [31:0]       op_colour = '0;
    logic              mem_re, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic [7:0]        mem_rdata = '0;
    logic              dirty_valid;
    logic [CRD_W-1:0]  dirty_x, dirty_y, dirty_w, dirty_h;

    always #5 clk = ~clk;

    rfe_engine #(.ADDR_W(ADDR_W), .CRD_W(CRD_W)) u0 (
        .clk(clk), .rst(rst), .cfg_depth(cfg_depth), .cfg_scr_w(cfg_scr_w),
        .op_valid(op_valid), .op_ready(op_ready), .op_kind(op_kind),
        .op_src_x(op_src_x), .op_src_y(op_src_y), .op_dst_x(op_dst_x), .op_dst_y(op_dst_y),
        .op_w(op_w), .op_h(op_h), .op_colour(op_colour),
        .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dirty_valid(dirty_valid), .dirty_x(dirty_x), .dirty_y(dirty_y),
        .dirty_w(dirty_w), .dirty_h(dirty_h)
    );

    function automatic logic [7:0] pat(input int i, input int s);
        return 8'((i * 13 + s * 29 + (i >> 4)) & 255);
    endfunction

    // byte memory with one cycle of read latency
    logic [7:0] mem [0:MEMSZ-1];
    logic       seed_req = 1'b0;
    int         seed_val = 0;

    always @(posedge clk) begin
        if (seed_req) begin
            for (int i = 0; i < MEMSZ; i++) mem[i] <= pat(i, seed_val);
        end else if (mem_we) begin
            mem[mem_addr[10:0]] <= mem_wdata;
        end
        if (mem_re) mem_rdata <= mem[mem_addr[10:0]];
    end

    // monitor: running totals sampled away from the active edge
    int acc_total = 0;
    int dirty_total = 0;
    logic [CRD_W-1:0] cap_x, cap_y, cap_w, cap_h;
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_re || mem_we) acc_total <= acc_total + 1;
            if (dirty_valid) begin
                dirty_total <= dirty_total + 1;
                cap_x <= dirty_x;
                cap_y <= dirty_y;
                cap_w <= dirty_w;
                cap_h <= dirty_h;
            end
        end
    end

    int total = 0;
    int bad = 0;
    logic [7:0] expm [0:MEMSZ-1];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic seed_mem(input int s);
        @(negedge clk);
        seed_val = s;
        seed_req = 1'b1;
        @(negedge clk);
        seed_req = 1'b0;
        for (int i = 0; i < MEMSZ; i++) expm[i] = pat(i, s);
    endtask

    task automatic issue_and_wait(input vec_t v, output bit hung);
        int n;
        @(negedge clk);
        cfg_depth = v.depth;
        op_kind   = v.kind;
        op_src_x  = CRD_W'(v.sx);
        op_src_y  = CRD_W'(v.sy);
        op_dst_x  = CRD_W'(v.dx);
        op_dst_y  = CRD_W'(v.dy);
        op_w      = CRD_W'(v.w);
        op_h      = CRD_W'(v.h);
        op_colour = v.col;
        op_valid  = 1'b1;
        @(negedge clk);
        op_valid  = 1'b0;
        n = 0;
        while (!op_ready && n < 5000) begin
            @(negedge clk);
            n++;
        end
        hung = (n >= 5000);
        @(negedge clk);
    endtask

    // reference result from the requirements: copies read an untouched snapshot
    task automatic model(input vec_t v, input int s);
        int bpp, pitch, sb, db;
        bpp   = (int'(v.depth) + 7) >> 3;
        pitch = bpp * SW;
        sb    = bpp * int'(v.sx) + pitch * int'(v.sy);
        db    = bpp * int'(v.dx) + pitch * int'(v.dy);
        for (int r = 0; r < int'(v.h); r++)
            for (int k = 0; k < bpp * int'(v.w); k++)
                expm[db + r * pitch + k] = v.kind
                    ? pat(sb + r * pitch + k, s)
                    : 8'(v.col >> (8 * (k % bpp)));
    endtask

    task automatic compare_mem(input string req, input string what);
        int nbad, first_a;
        nbad = 0;
        first_a = -1;
        for (int i = 0; i < MEMSZ; i++)
            if (mem[i] !== expm[i]) begin
                if (first_a < 0) first_a = i;
                nbad++;
            end
        if (first_a < 0) check(1'b1, req, what, 0, 0);
        else check(1'b0, req, {what, " byte at first bad address"},
                   int'(mem[first_a]), int'(expm[first_a]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit hung;
        int d0, a0;
        string req;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check(op_ready == 1'b1, "R12", "op_ready after reset", int'(op_ready), 1);
        check(!mem_re && !mem_we, "R12", "memory strobes after reset", int'({mem_re, mem_we}), 0);
        check(dirty_valid == 1'b0, "R12", "dirty_valid after reset", int'(dirty_valid), 0);

        // vector table: R1 R2 fills, R3..R7 copies, R8 dirty, R10 full compare, R11 via copies
        for (int t = 0; t < NV; t++) begin
            case (t)
                0, 1, 2, 3, 4: req = "R1/R2/R10";
                5: req = "R3/R10/R11";
                6: req = "R4/R10/R11";
                7: req = "R5/R10/R11";
                8: req = "R6/R10/R11";
                default: req = "R7/R10/R11";
            endcase
            seed_mem(t + 1);
            model(VECS[t], t + 1);
            d0 = dirty_total;
            issue_and_wait(VECS[t], hung);
            check(!hung, req, $sformatf("vector %0d completion", t), int'(hung), 0);
            compare_mem(req, $sformatf("vector %0d memory", t));
            check((dirty_total - d0 == 1) && cap_x == CRD_W'(VECS[t].dx) &&
                  cap_y == CRD_W'(VECS[t].dy) && cap_w == CRD_W'(VECS[t].w) &&
                  cap_h == CRD_W'(VECS[t].h),
                  "R8", $sformatf("vector %0d dirty count/x/y/w/h packed", t),
                  (dirty_total - d0) * 1000000 + int'(cap_x) * 10000 + int'(cap_y) * 100 + int'(cap_w),
                  1000000 + int'(VECS[t].dx) * 10000 + int'(VECS[t].dy) * 100 + int'(VECS[t].w));
        end

        // R9 zero width fill
        seed_mem(40);
        d0 = dirty_total;
        a0 = acc_total;
        issue_and_wait('{1'b0, 6'd32, 8'd0, 8'd0, 8'd2, 8'd2, 8'd0, 8'd3, 32'hFFFFFFFF}, hung);
        compare_mem("R9", "zero width fill memory");
        check((dirty_total == d0) && (acc_total == a0) && op_ready, "R9",
              "zero width fill dirty+access count", (dirty_total - d0) + (acc_total - a0), 0);

        // R9 zero height copy
        seed_mem(41);
        d0 = dirty_total;
        a0 = acc_total;
        issue_and_wait('{1'b1, 6'd8, 8'd0, 8'd0, 8'd5, 8'd5, 8'd4, 8'd0, 32'h0}, hung);
        compare_mem("R9", "zero height copy memory");
        check((dirty_total == d0) && (acc_total == a0) && op_ready, "R9",
              "zero height copy dirty+access count", (dirty_total - d0) + (acc_total - a0), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule